// File: doc/BRIEF.md
# Two-Level ALU Decoder and 32-bit ALU

This block turns a coarse operation class from the main instruction controller, together with the function field of a register-format instruction, into a 3-bit operation code. It then carries out that operation on two 32-bit operands. Loads and stores always get an addition, which forms their address. Branch-on-equal always gets a subtraction, and the branch logic reads the Zero flag from it. Register-format arithmetic takes its operation from the function field.

The ALU supports AND, OR, add, subtract and signed set-on-less-than. The top bit of the operation code both inverts operand B and supplies the adder's carry-in, so a single adder handles add, subtract and the comparison. The compare result is the sign of the difference, corrected for signed overflow. The block is purely combinational.

Top module: `aluTop`

## Requirements
- R1: With aluOp = 00 the operation code is 010 (add) and the result is opA + opB modulo 2^32, whatever the function field holds.
- R2: With aluOp = 01 the operation code is 110 (subtract) and the result is opA - opB modulo 2^32, whatever the function field holds.
- R3: With aluOp[1] = 1, the function field selects the operation code: 100100 gives 000 (AND), 100101 gives 001 (OR), 100000 gives 010 (add), 100010 gives 110 (subtract) and 101010 gives 111 (set-on-less-than).
- R4: With aluOp[1] = 1 and any other function field value, the operation code falls back to 010 (add).
- R5: Operation code 000 gives the bitwise AND of the operands, and 001 gives the bitwise OR.
- R6: Subtraction adds the inverted B operand with a carry-in of 1, so the result wraps modulo 2^32 (for example, 0 - 1 = 0xFFFFFFFF). Bit 2 of the operation code is 1 exactly for subtract and set-on-less-than.
- R7: Operation code 111 gives a result of 1 when opA < opB as signed two's-complement numbers and 0 otherwise. Bits 31..1 are always 0, and the comparison stays correct when opA - opB overflows.
- R8: zero is 1 exactly when all 32 result bits are 0. Under subtraction this means it is 1 exactly when opA equals opB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluOp | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | output | 3 | Decoded ALU operation code |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the block with its default 32-bit data width and 6-bit function field. At that width the edge values matter: the most negative and most positive numbers, the wraparound of all-ones plus one, and subtractions that overflow in both directions. These are exactly the cases where set-on-less-than would go wrong if it used the raw sign bit. Random operands, random operation classes and random function fields, legal and illegal, cover the decode table and the fallback.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } resultSelT;

  // strobes handed from the control decoder to the datapath
  typedef struct packed {
    logic      bInvert;   // inverts B and doubles as adder carry-in
    resultSelT resultSel;
  } aluStrobesT;

  localparam logic [2:0] OPC_AND  = 3'b000;
  localparam logic [2:0] OPC_OR   = 3'b001;
  localparam logic [2:0] OPC_ADD  = 3'b010;
  localparam logic [2:0] OPC_SUB  = 3'b110;
  localparam logic [2:0] OPC_SLT  = 3'b111;

  localparam logic [1:0] CLASS_MEM    = 2'b00;
  localparam logic [1:0] CLASS_BRANCH = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
#(
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         aluOp,
  input  logic [FUNCT_W-1:0] funct,
  output logic [2:0]         opCode,
  output aluStrobesT         strobes
);

  logic [2:0] functCode;

  // second level: function field decode
  always_comb begin
    if (funct == FUNCT_W'(FN_AND))      functCode = OPC_AND;
    else if (funct == FUNCT_W'(FN_OR))  functCode = OPC_OR;
    else if (funct == FUNCT_W'(FN_SUB)) functCode = OPC_SUB;
    else if (funct == FUNCT_W'(FN_SLT)) functCode = OPC_SLT;
    else                                functCode = OPC_ADD;
  end

  // first level: operation class
  always_comb begin
    if (aluOp[1])                     opCode = functCode;
    else if (aluOp == CLASS_BRANCH)   opCode = OPC_SUB;
    else                              opCode = OPC_ADD;
  end

  always_comb begin
    strobes.bInvert   = opCode[2];
    strobes.resultSel = resultSelT'(opCode[1:0]);
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             bInvert,
  output logic [WIDTH-1:0] sum,
  output logic             overflow
);

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   wide;
  logic             carryIntoMsb;

  always_comb begin
    bEff = b ^ {WIDTH{bInvert}};
    // the same strobe is the carry-in
    wide = {1'b0, a} + {1'b0, bEff} + {{WIDTH{1'b0}}, bInvert};
    sum = wide[WIDTH-1:0];
    carryIntoMsb = wide[WIDTH-1] ^ a[WIDTH-1] ^ bEff[WIDTH-1];
    overflow = wide[WIDTH] ^ carryIntoMsb;
  end

endmodule

// File: rtl/aluSlice.sv
module aluSlice
  import aluPkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      sumBit,
  input  logic      lessBit,
  input  resultSelT sel,
  output logic      y
);

  always_comb begin
    unique case (sel)
      SEL_AND:  y = a & b;
      SEL_OR:   y = a | b;
      SEL_SUM:  y = sumBit;
      SEL_LESS: y = lessBit;
      default:  y = 1'b0;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobesT       strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  logic [WIDTH-1:0] sum;
  logic             overflow;
  logic             signedLess;

  aluAdder #(.WIDTH(WIDTH)) uAdder (
    .a        (opA),
    .b        (opB),
    .bInvert  (strobes.bInvert),
    .sum      (sum),
    .overflow (overflow)
  );

  // sign of the difference, corrected when the difference overflowed
  assign signedLess = sum[WIDTH-1] ^ overflow;

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    logic lessIn;
    if (i == 0) begin : gLsb
      assign lessIn = signedLess;
    end else begin : gUpper
      assign lessIn = 1'b0;
    end
    aluSlice uSlice (
      .a       (opA[i]),
      .b       (opB[i]),
      .sumBit  (sum[i]),
      .lessBit (lessIn),
      .sel     (strobes.resultSel),
      .y       (result[i])
    );
  end

  assign zero = ~|result;

endmodule

// File: rtl/aluTop.sv
module aluTop
  import aluPkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         aluOp,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2:0]         opCode,
  output logic [WIDTH-1:0]   result,
  output logic               zero
);

  aluStrobesT strobes;

  aluCtrl #(.FUNCT_W(FUNCT_W)) uCtrl (
    .aluOp   (aluOp),
    .funct   (funct),
    .opCode  (opCode),
    .strobes (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) uDatapath (
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .zero    (zero)
  );

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int WIDTH   = 32,
  parameter int FUNCT_W = 6
) (
  input logic [1:0]         aluOp,
  input logic [FUNCT_W-1:0] funct,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [2:0]         opCode,
  input logic [WIDTH-1:0]   result,
  input logic               zero
);

  logic unusedFunct;
  assign unusedFunct = ^funct;

  always_comb begin
    if (aluOp == 2'b00) AST_MEM_ADD: assert (opCode == 3'b010);  // R1
    if (aluOp == 2'b01) AST_BRANCH_SUB: assert (opCode == 3'b110);  // R2
    AST_CODE_LEGAL: assert (opCode inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111});  // R3
    if (opCode == 3'b000) AST_AND_BITS: assert (result == (opA & opB));  // R5
    if (opCode == 3'b110) AST_SUB_WRAP: assert (result + opB == opA);  // R6
    if (opCode == 3'b111) AST_SLT_BOOL: assert (result[WIDTH-1:1] == '0);  // R7
    if (opCode == 3'b110) AST_SUB_ZERO: assert (zero == (opA == opB));  // R8
  end

endmodule

bind aluTop aluChecker #(.WIDTH(WIDTH), .FUNCT_W(FUNCT_W)) uChecker (
  .aluOp  (aluOp),
  .funct  (funct),
  .opA    (opA),
  .opB    (opB),
  .opCode (opCode),
  .result (result),
  .zero   (zero)
);

// File: tb/tb_aluTop.sv
module tb_aluTop;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;

  logic [1:0]       aluOp;
  logic [5:0]       funct;
  logic [WIDTH-1:0] opA, opB;
  logic [2:0]       opCode;
  logic [WIDTH-1:0] result;
  logic             zero;

  always #(CLK_PERIOD/2) clk = ~clk;

  aluTop dut (
    .aluOp(aluOp), .funct(funct), .opA(opA), .opB(opB),
    .opCode(opCode), .result(result), .zero(zero)
  );

  function automatic logic [2:0] expCode(input logic [1:0] op, input logic [5:0] fn);
    if (op == 2'b00) return 3'b010;
    if (op == 2'b01) return 3'b110;
    case (fn)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] expResult(input logic [2:0] c,
                                                 input logic [WIDTH-1:0] a,
                                                 input logic [WIDTH-1:0] b);
    case (c)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b110:  return a - b;
      3'b111:  return ($signed(a) < $signed(b)) ? 1 : 0;
      default: return a + b;
    endcase
  endfunction

  function automatic string reqOf(input logic [1:0] op, input logic [2:0] c);
    if (op == 2'b00) return "R1";
    if (op == 2'b01) return "R2";
    case (c)
      3'b000, 3'b001: return "R5";
      3'b110:         return "R6";
      3'b111:         return "R7";
      default:        return "R3";
    endcase
  endfunction

  task automatic applyCheck(input logic [1:0] op, input logic [5:0] fn,
                            input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                            input string tag);
    logic [2:0]       eC;
    logic [WIDTH-1:0] eR;
    logic             eZ;
    @(negedge clk);
    aluOp = op; funct = fn; opA = a; opB = b;
    eC = expCode(op, fn);
    eR = expResult(eC, a, b);
    eZ = (eR == '0);
    @(posedge clk);
    #1;
    checks++;
    if (opCode !== eC) begin
      errors++;
      $display("FAIL %s opCode actual %b expected %b (op %b fn %b)", tag, opCode, eC, op, fn);
    end
    checks++;
    if (result !== eR) begin
      errors++;
      $display("FAIL %s result actual %h expected %h (a %h b %h code %b)", tag, result, eR, a, b, eC);
    end
    checks++;
    if (zero !== eZ) begin
      errors++;
      $display("FAIL R8 zero actual %b expected %b (result %h)", zero, eZ, eR);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] legal [5];
    int unsigned seed;
    legal[0] = 6'b100000; legal[1] = 6'b100010; legal[2] = 6'b100100;
    legal[3] = 6'b100101; legal[4] = 6'b101010;
    seed = 32'd12345;
    void'($urandom(seed));
    aluOp = 2'b00; funct = '0; opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state: add of zeros
    applyCheck(2'b00, 6'b000000, 32'h0, 32'h0, "R1");
    // R1: add ignores funct, wraps
    applyCheck(2'b00, 6'b100010, 32'hFFFFFFFF, 32'h1, "R1");
    applyCheck(2'b00, 6'b101010, 32'h1234, 32'h10, "R1");
    // R2: branch subtract and equality
    applyCheck(2'b01, 6'b100100, 32'hDEADBEEF, 32'hDEADBEEF, "R2");
    applyCheck(2'b01, 6'b000000, 32'h5, 32'h6, "R2");
    // R3: every legal funct, both aluOp 10 and 11
    for (int i = 0; i < 5; i++) begin
      applyCheck(2'b10, legal[i], 32'hF0F0_1234, 32'h0FF0_4321, "R3");
      applyCheck(2'b11, legal[i], 32'h8000_0000, 32'h7FFF_FFFF, "R3");
    end
    // R4: unknown funct falls back to add
    applyCheck(2'b10, 6'b000000, 32'h3, 32'h4, "R4");
    applyCheck(2'b10, 6'b111111, 32'h7FFFFFFF, 32'h1, "R4");
    applyCheck(2'b11, 6'b100001, 32'h10, 32'h20, "R4");
    // R5: and/or edges
    applyCheck(2'b10, 6'b100100, 32'hAAAAAAAA, 32'h55555555, "R5");
    applyCheck(2'b10, 6'b100101, 32'hAAAAAAAA, 32'h55555555, "R5");
    // R6: subtraction wrap
    applyCheck(2'b10, 6'b100010, 32'h0, 32'h1, "R6");
    applyCheck(2'b10, 6'b100010, 32'h80000000, 32'h1, "R6");
    // R7: slt with overflowing differences
    applyCheck(2'b10, 6'b101010, 32'h80000000, 32'h7FFFFFFF, "R7");
    applyCheck(2'b10, 6'b101010, 32'h7FFFFFFF, 32'h80000000, "R7");
    applyCheck(2'b10, 6'b101010, 32'hFFFFFFFF, 32'h0, "R7");
    applyCheck(2'b10, 6'b101010, 32'h5, 32'h5, "R7");
    applyCheck(2'b10, 6'b101010, 32'h1, 32'hFFFFFFFF, "R7");
    // R8: zero on and-to-nothing
    applyCheck(2'b10, 6'b100100, 32'hF0F0F0F0, 32'h0F0F0F0F, "R8");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]       op;
      logic [5:0]       fn;
      logic [WIDTH-1:0] a, b;
      op = 2'($urandom());
      fn = ($urandom_range(0, 3) != 0) ? legal[$urandom_range(0, 4)] : 6'($urandom());
      a = $urandom();
      b = ($urandom_range(0, 7) == 0) ? a : $urandom();
      applyCheck(op, fn, a, b, reqOf(op, expCode(op, fn)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule